// File: doc/BRIEF.md
# Converter Status and Interrupt Flag Register

This block collects completion and error events from a sixteen-channel converter sequencer and holds them as sticky flags in one 32-bit status word. Each event arrives as a one-cycle pulse that is already in the bus clock domain. A conversion-done pulse carries the index of the channel it finished. A comparator-hit pulse carries the index of the channel that matched. Single-bit pulses report end of scan, a new filter sample and a synchronizer overflow.

Software reads the status word over a small register bus and clears any flag by writing a one to its bit. A separate interrupt-enable mask is changed through dedicated set and clear addresses. The block drives a single level interrupt, which is the registered OR of the enabled single-bit flags. The per-channel ready flags and the two channel-index fields are informational only and never raise the interrupt.

The bus has no back-pressure: a write is accepted on every clock edge where `bus_we_i` is high, and the read data is a combinational function of the address. Address map (`bus_addr_i`): 0 = status word (read, write-one-to-clear), 1 = enable mask (read), 2 = enable set (write ones), 3 = enable clear (write ones).

Top module: `conv_status_irq`

## Requirements
- R1: Status bit 16+k is set on the edge where `done_i` is high with `done_chan_i` = k. It stays set until software writes 1 to that bit at address 0.
- R2: A conversion-done pulse loads its channel index into status bits 15:12 and sets the current-ready flag at bit 8 on the same edge.
- R3: The overwrite flag at bit 10 is set when a conversion-done pulse arrives while bit 8 is set and bit 8 is not being cleared in that same cycle.
- R4: The end-of-scan pulse sets bit 11. The filter-ready pulse sets bit 9. The overflow pulse sets bit 7.
- R5: A comparator-hit pulse sets bit 6 and loads `cmp_chan_i` into bits 3:0. Bits 5:4 always read as zero.
- R6: Bits 31:16, 15:12 and 3:0 never contribute to `irq_o`, whatever the enable mask holds.
- R7: `irq_o` is the OR of status bits 11, 10, 9, 8, 7 and 6, each ANDed with the enable bit at the same position. It is registered, so it follows a flag change one cycle later.
- R8: All fields reset to zero. A write to address 0 clears exactly the bits written as 1, and a bit written as 0 keeps its value.
- R9: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set. For the index fields, the new index is loaded.
- R10: A write to address 2 sets, and a write to address 3 clears, every enable bit written as 1. Only bits 11:6 are implemented, and address 1 reads the mask with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 1 | Conversion completed (pulse) |
| done_chan_i | input | 4 | Channel index of the completed conversion |
| eos_i | input | 1 | Last channel of a scan completed (pulse) |
| filt_i | input | 1 | Filter produced a new sample (pulse) |
| sovf_i | input | 1 | Synchronizer overflow (pulse) |
| cmp_i | input | 1 | Comparator hit (pulse) |
| cmp_chan_i | input | 4 | Channel index of the comparator hit |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench checks a completion that lands in the same cycle as a clear of the current-ready flag. A design that tests the flag before honouring the clear would report a false overwrite there. It also fires set and clear together on the same channel flag and on bit 8, where a design that let the clear win would lose an event. Writes of zero must leave the word untouched. The bench steps `irq_o` edge by edge on the way up and on the way down, so an unregistered output or an extra stage would be caught. With the matching enables on, it checks that index fields and per-channel flags never reach the interrupt line, which would catch a mask applied across the whole word.

// File: rtl/conv_flags_pkg.sv
package conv_flags_pkg;
  localparam int NCH      = 16;
  localparam int IDW      = $clog2(NCH);
  localparam int DW       = 32;
  localparam int CH_LO    = 16;
  localparam int ID_LO    = 12;
  localparam int B_EOS    = 11;
  localparam int B_OVW    = 10;
  localparam int B_FLT    = 9;
  localparam int B_CUR    = 8;
  localparam int B_SOV    = 7;
  localparam int B_CMP    = 6;
  localparam int CMPID_LO = 0;
  localparam logic [DW-1:0] IRQ_MASK =
    (DW'(1) << B_EOS) | (DW'(1) << B_OVW) | (DW'(1) << B_FLT) |
    (DW'(1) << B_CUR) | (DW'(1) << B_SOV) | (DW'(1) << B_CMP);

  typedef enum logic [1:0] {
    A_FLAGS  = 2'd0,
    A_EN_RD  = 2'd1,
    A_EN_SET = 2'd2,
    A_EN_CLR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/conv_sticky_bits.sv
module conv_sticky_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[k] <= 1'b0;
      else if (set_i[k]) q_o[k] <= 1'b1;
      else if (clr_i[k]) q_o[k] <= 1'b0;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> q_o[k]);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !q_o[k]);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[k] && !set_i[k]) |=> (q_o[k] == $past(q_o[k])));
  end
endmodule

// File: rtl/conv_chan_track.sv
module conv_chan_track #(
  parameter int NCH = 16,
  parameter int IDW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done_i,
  input  logic [IDW-1:0] chan_i,
  input  logic [NCH-1:0] clr_rdy_i,
  input  logic [IDW-1:0] clr_id_i,
  input  logic           clr_cur_i,
  input  logic           clr_ow_i,
  output logic [NCH-1:0] rdy_q,
  output logic [IDW-1:0] id_q,
  output logic           cur_q,
  output logic           ow_q
);
  logic ow_set;

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rdy_q[k] <= 1'b0;
      else if (done_i && chan_i == IDW'(k)) rdy_q[k] <= 1'b1;
      else if (clr_rdy_i[k])               rdy_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      id_q <= '0;
    else if (done_i) id_q <= chan_i;
    else             id_q <= id_q & ~clr_id_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_q <= 1'b0;
    else if (done_i)    cur_q <= 1'b1;
    else if (clr_cur_i) cur_q <= 1'b0;
  end

  // a clear of the current-ready flag in the same cycle cancels the overwrite
  assign ow_set = done_i && cur_q && !clr_cur_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ow_q <= 1'b0;
    else if (ow_set)   ow_q <= 1'b1;
    else if (clr_ow_i) ow_q <= 1'b0;
  end

  p_chan_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> rdy_q[$past(chan_i)]);
  p_cur_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (cur_q && id_q == $past(chan_i)));
  p_ow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ow_q) |-> ($past(done_i) && $past(cur_q) && !$past(clr_cur_i)));
endmodule

// File: rtl/conv_irq_mask.sv
module conv_irq_mask #(
  parameter int              DW   = 32,
  parameter logic [DW-1:0]   MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_wr_i,
  input  logic          clr_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] flags_i,
  output logic [DW-1:0] en_q,
  output logic          irq_q
);
  logic [DW-1:0] set_bits, clr_bits;
  logic          req;

  assign set_bits = set_wr_i ? wdata_i : '0;
  assign clr_bits = clr_wr_i ? wdata_i : '0;
  assign req      = |(flags_i & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_bits) & ~clr_bits & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req;
  end

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_i & en_q & MASK)) |=> irq_q);
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags_i & en_q & MASK)) |=> !irq_q);
  p_en_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr_i && !clr_wr_i) |=> ((en_q & $past(wdata_i) & MASK) == ($past(wdata_i) & MASK)));
endmodule

// File: rtl/conv_status_irq.sv
module conv_status_irq
  import conv_flags_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done_i,
  input  logic [3:0]  done_chan_i,
  input  logic        eos_i,
  input  logic        filt_i,
  input  logic        sovf_i,
  input  logic        cmp_i,
  input  logic [3:0]  cmp_chan_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  logic [DW-1:0]  clr, flags, en_q;
  logic [NCH-1:0] rdy_q;
  logic [IDW-1:0] id_q, cmpid_q;
  logic           cur_q, ow_q;
  logic [3:0]     ev_set, ev_clr, ev_q;
  logic           wr_set, wr_clr;

  assign clr    = (bus_we_i && bus_addr_i == A_FLAGS) ? bus_wdata_i : '0;
  assign wr_set = bus_we_i && bus_addr_i == A_EN_SET;
  assign wr_clr = bus_we_i && bus_addr_i == A_EN_CLR;

  conv_chan_track #(.NCH(NCH), .IDW(IDW)) u_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (done_i),
    .chan_i    (done_chan_i),
    .clr_rdy_i (clr[CH_LO +: NCH]),
    .clr_id_i  (clr[ID_LO +: IDW]),
    .clr_cur_i (clr[B_CUR]),
    .clr_ow_i  (clr[B_OVW]),
    .rdy_q     (rdy_q),
    .id_q      (id_q),
    .cur_q     (cur_q),
    .ow_q      (ow_q)
  );

  // order: end of scan, filter, overflow, compare hit
  assign ev_set = {eos_i, filt_i, sovf_i, cmp_i};
  assign ev_clr = {clr[B_EOS], clr[B_FLT], clr[B_SOV], clr[B_CMP]};

  conv_sticky_bits #(.N(4)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_set),
    .clr_i (ev_clr),
    .q_o   (ev_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmpid_q <= '0;
    else if (cmp_i) cmpid_q <= cmp_chan_i;
    else            cmpid_q <= cmpid_q & ~clr[CMPID_LO +: IDW];
  end

  always_comb begin
    flags                    = '0;
    flags[CH_LO +: NCH]      = rdy_q;
    flags[ID_LO +: IDW]      = id_q;
    flags[B_EOS]             = ev_q[3];
    flags[B_OVW]             = ow_q;
    flags[B_FLT]             = ev_q[2];
    flags[B_CUR]             = cur_q;
    flags[B_SOV]             = ev_q[1];
    flags[B_CMP]             = ev_q[0];
    flags[CMPID_LO +: IDW]   = cmpid_q;
  end

  conv_irq_mask #(.DW(DW), .MASK(IRQ_MASK)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_wr_i (wr_set),
    .clr_wr_i (wr_clr),
    .wdata_i  (bus_wdata_i),
    .flags_i  (flags),
    .en_q     (en_q),
    .irq_q    (irq_o)
  );

  always_comb begin
    case (bus_addr_i)
      A_FLAGS: bus_rdata_o = flags;
      A_EN_RD: bus_rdata_o = en_q;
      default: bus_rdata_o = '0;
    endcase
  end

  p_cmp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_i |=> (bus_addr_i != A_FLAGS || (bus_rdata_o[3:0] == $past(cmp_chan_i)
                                         && bus_rdata_o[6] && bus_rdata_o[5:4] == 2'b00)));
  p_info_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & IRQ_MASK) == '0) |=> !irq_o);
endmodule

// File: tb/conv_status_irq_test.sv
module conv_status_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_i = 1'b0, eos_i = 1'b0, filt_i = 1'b0, sovf_i = 1'b0, cmp_i = 1'b0;
  logic [3:0]  done_chan_i = '0, cmp_chan_i = '0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  conv_status_irq uut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .done_chan_i(done_chan_i),
    .eos_i(eos_i), .filt_i(filt_i), .sovf_i(sovf_i), .cmp_i(cmp_i),
    .cmp_chan_i(cmp_chan_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  // {we, done, chan[3:0], eos, filt, sovf, cmp, cmpchan[3:0], wdata[31:0], expected[31:0]}
  localparam int NV = 12;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd3,  4'b0000, 4'd0, 32'h0000_0000, 32'h0008_3100},
    {1'b0, 1'b1, 4'd5,  4'b0000, 4'd0, 32'h0000_0000, 32'h0028_5500},
    {1'b1, 1'b0, 4'd0,  4'b0000, 4'd0, 32'h0000_0000, 32'h0028_5500},
    {1'b1, 1'b0, 4'd0,  4'b0000, 4'd0, 32'h0000_FF00, 32'h0028_0000},
    {1'b0, 1'b1, 4'd0,  4'b0000, 4'd0, 32'h0000_0000, 32'h0029_0100},
    {1'b1, 1'b1, 4'd15, 4'b0000, 4'd0, 32'h0000_0100, 32'h8029_F100},
    {1'b0, 1'b0, 4'd0,  4'b0001, 4'd9, 32'h0000_0000, 32'h8029_F149},
    {1'b0, 1'b0, 4'd0,  4'b1110, 4'd0, 32'h0000_0000, 32'h8029_FBC9},
    {1'b1, 1'b0, 4'd0,  4'b0001, 4'd2, 32'hFFFF_FFFF, 32'h0000_0042},
    {1'b1, 1'b0, 4'd0,  4'b0000, 4'd0, 32'h0000_0042, 32'h0000_0000},
    {1'b1, 1'b1, 4'd7,  4'b0000, 4'd0, 32'h0080_0000, 32'h0080_7100},
    {1'b1, 1'b0, 4'd0,  4'b0000, 4'd0, 32'h0080_7100, 32'h0000_0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    done_i = 0; eos_i = 0; filt_i = 0; sovf_i = 0; cmp_i = 0;
    bus_we_i = 0; bus_addr_i = 2'd0; bus_wdata_i = '0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    tick();
    idle();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    check("R8 reset flags", bus_rdata_o, 32'h0);
    bus_addr_i = 2'd1; #1;
    check("R10 reset enable", bus_rdata_o, 32'h0);
    bus_addr_i = 2'd0;
    check("R7 reset irq", {31'h0, irq_o}, 32'h0);

    // vector table walk: R1 R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NV; i++) begin
      bus_we_i    = VEC[i][77];
      done_i      = VEC[i][76];
      done_chan_i = VEC[i][75:72];
      eos_i       = VEC[i][71];
      filt_i      = VEC[i][70];
      sovf_i      = VEC[i][69];
      cmp_i       = VEC[i][68];
      cmp_chan_i  = VEC[i][67:64];
      bus_addr_i  = 2'd0;
      bus_wdata_i = VEC[i][63:32];
      tick();
      idle();
      #1;
      check($sformatf("R1 R2 R3 R4 R5 R8 R9 table step %0d", i), bus_rdata_o, VEC[i][31:0]);
      check($sformatf("R6 no irq with mask off, step %0d", i), {31'h0, irq_o}, 32'h0);
    end

    // enable mask set/clear
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_addr_i = 2'd1; #1;
    check("R10 enable set readback", bus_rdata_o, 32'h0000_0FC0);
    bus_write(2'd3, 32'h0000_0040);
    bus_addr_i = 2'd1; #1;
    check("R10 enable clear readback", bus_rdata_o, 32'h0000_0F80);
    bus_addr_i = 2'd0;

    // interrupt latency on rise and fall
    filt_i = 1; tick(); idle(); #1;
    check("R7 irq one cycle after flag set (still low)", {31'h0, irq_o}, 32'h0);
    tick();
    check("R7 irq high", {31'h0, irq_o}, 32'h1);
    bus_write(2'd0, 32'h0000_0200); #1;
    check("R7 irq still high on clear edge", {31'h0, irq_o}, 32'h1);
    tick();
    check("R7 irq low after clear", {31'h0, irq_o}, 32'h0);

    // index fields and per-channel flags never interrupt
    bus_write(2'd3, 32'h0000_0100);
    done_i = 1; done_chan_i = 4'd7; cmp_i = 1; cmp_chan_i = 4'd4;
    bus_wdata_i = '0;
    bus_write(2'd2, 32'hFFFF_0000);
    tick(); tick();
    bus_addr_i = 2'd0; #1;
    check("R6 info fields latched", bus_rdata_o, 32'h0080_7144);
    check("R6 irq stays low", {31'h0, irq_o}, 32'h0);
    bus_write(2'd0, 32'hFFFF_FFFF);

    // overwrite raises irq through bit 10
    done_i = 1; done_chan_i = 4'd1; tick(); idle();
    done_i = 1; done_chan_i = 4'd2; tick(); idle(); #1;
    check("R3 overwrite flags", bus_rdata_o, 32'h0006_2500);
    tick();
    check("R3 overwrite irq", {31'h0, irq_o}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule